// File: doc/BRIEF.md
# Row-Hit-First Single-Bank Request Scheduler

This block orders memory requests for one DRAM bank that several hardware threads share. Requests enter through a valid/ready port and wait in an eight-entry buffer. Each entry holds the thread ID, the row, the 7-bit column (a row holds 128 block-sized columns), a read/write flag and an arrival sequence number.

The scheduler remembers which row was last opened in the bank. Whenever the bank is free, it picks one pending request. A request to the open row goes ahead of every request to another row. Within the same class (hit or conflict), the earliest arrival wins. The pick leaves on the issue port as a one-cycle pulse carrying a hit flag. The scheduler then waits a short period after a hit and a long one after a conflict, which models the extra cost of closing one row and opening another.

Per-thread issue counters are brought out so that the service each thread receives can be observed. With this policy a thread that streams through one row can be served 128 times while an older conflicting request from another thread waits. That starvation is a property of the policy and is not corrected here.

The controller is a two-state machine. **ST_READY** is where a selection may happen. **ST_BUSY** holds off selection while the latency counter runs. Transition **ISSUE** (ST_READY→ST_BUSY) fires on the edge where a request is picked. Transition **DRAIN** (ST_BUSY→ST_READY) fires on the edge where the counter reaches its last cycle.

Top module: `rowhit_sched`

## Requirements
- R1: When any pending request targets the open row, the issued request is one of those hits, however old the conflicting requests are.
- R2: Among pending requests of the same class (all hits or all conflicts), the one accepted earliest is issued first.
- R3: `iss_valid` pulses for exactly one cycle, in the cycle after the selecting edge. The next selection edge comes HIT_LAT (3) cycles after a hit selection and MISS_LAT (9) cycles after a conflict selection.
- R4: Every issue makes its row the open row. `iss_hit` is 1 exactly when `iss_row` equals the row of the previous issue since reset.
- R5: After reset no row is open, so the first issue always has `iss_hit` = 0.
- R6: The buffer holds 8 requests. `req_ready` is 1 out of reset and is 0 exactly while 8 requests are pending. A request presented while `req_ready` is 0 is dropped and is never issued.
- R7: No selection happens on an edge where `bank_busy` is 1. Pending requests stay buffered until it falls.
- R8: The issue port carries the thread ID, row, column and write flag of the selected request, unchanged.
- R9: `thr_cnt[t*16 +: 16]` counts the issues for thread `t`. All counters are 0 out of reset.
- R10: Columns are 7 bits (128 per row). If one thread keeps the buffer topped up with requests to the open row, all 128 of its columns are issued before an older request from another thread to a different row.
- R11: Age order stays correct after the 9-bit arrival sequence wraps, for any number of arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Buffer has a free slot |
| req_wr | input | 1 | Request is a write |
| req_tid | input | 2 | Thread ID of the request |
| req_row | input | 8 | Row address |
| req_col | input | 7 | Column (block within the row) |
| bank_busy | input | 1 | Bank cannot accept a command this cycle |
| iss_valid | output | 1 | One-cycle issue pulse |
| iss_wr | output | 1 | Write flag of the issued request |
| iss_tid | output | 2 | Thread ID of the issued request |
| iss_row | output | 8 | Row of the issued request |
| iss_col | output | 7 | Column of the issued request |
| iss_hit | output | 1 | Issue hit the open row |
| thr_cnt | output | 64 | Four 16-bit per-thread issue counters |

## Verification
A corrupted open-row register shows up on the next issue, as a wrong `iss_hit` or as a hit issued ahead of an older conflict that should not have been bypassed. A broken age comparison shows up as an out-of-order column within the same class as soon as two same-class entries compete, and a wrap fault shows up only after 512 arrivals, so the sweep runs well past that point. A latency counter that is off by one changes the spacing of the very next pair of issues. An occupancy error shows up as `req_ready` disagreeing with the count of accepted-but-unissued requests in the same cycle.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
    localparam int TID_W = 2;
    localparam int ROW_W = 8;
    localparam int COL_W = 7;
    localparam int SEQ_W = 9;

    typedef struct packed {
        logic             wr;
        logic [TID_W-1:0] tid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [SEQ_W-1:0] seq;
    } req_t;

    typedef enum logic [0:0] {ST_READY, ST_BUSY} st_t;

    // a arrived before b when the modular difference is negative
    function automatic logic seq_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction
endpackage

// File: rtl/rhs_buffer.sv
module rhs_buffer
    import rhs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  req_t             push_req,
    input  logic             pop,
    input  logic [IDX_W-1:0] pop_idx,
    output req_t             ent [DEPTH],
    output logic [DEPTH-1:0] vld,
    output logic             full
);
    logic [SEQ_W-1:0] seq_q;
    logic [IDX_W-1:0] free_idx;
    req_t             wr_ent;

    assign full = &vld;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
        wr_ent     = push_req;
        wr_ent.seq = seq_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            seq_q <= '0;
        end else begin
            if (push && !full) seq_q <= seq_q + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (push && !full && free_idx == IDX_W'(i)) vld[i] <= 1'b1;
                else if (pop && pop_idx == IDX_W'(i))       vld[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && !full && free_idx == IDX_W'(i)) ent[i] <= wr_ent;
        end
    end
endmodule

// File: rtl/rhs_picker.sv
module rhs_picker
    import rhs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  req_t             ent [DEPTH],
    input  logic [DEPTH-1:0] vld,
    input  logic             open_vld,
    input  logic [ROW_W-1:0] open_row,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic             h;
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        any      = 1'b0;
        idx      = '0;
        hit      = 1'b0;
        best_seq = '0;
        h        = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            h = open_vld && (ent[i].row == open_row);
            if (vld[i] && (!any || (h && !hit) ||
                           (h == hit && seq_older(ent[i].seq, best_seq)))) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                hit      = h;
                best_seq = ent[i].seq;
            end
        end
    end
endmodule

// File: rtl/rhs_fsm.sv
module rhs_fsm
    import rhs_pkg::*;
#(
    parameter int HIT_LAT  = 3,
    parameter int MISS_LAT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic bank_busy,
    input  logic pick_hit,
    output logic issue
);
    localparam int CW = $clog2(MISS_LAT + 1);

    st_t           st, st_nx;
    logic [CW-1:0] cnt;

    // next state: ISSUE leaves ST_READY, DRAIN returns to it
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_READY: if (issue)           st_nx = ST_BUSY;
            ST_BUSY:  if (cnt == CW'(1))   st_nx = ST_READY;
            default:                       st_nx = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_READY;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (issue)              cnt <= pick_hit ? CW'(HIT_LAT - 1) : CW'(MISS_LAT - 1);
            else if (st == ST_BUSY) cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        issue = (st == ST_READY) && pend && !bank_busy;
    end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
    import rhs_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HIT_LAT  = 3,
    parameter int MISS_LAT = 9,
    parameter int CNT_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_wr,
    input  logic [rhs_pkg::TID_W-1:0]        req_tid,
    input  logic [rhs_pkg::ROW_W-1:0]        req_row,
    input  logic [rhs_pkg::COL_W-1:0]        req_col,
    input  logic                             bank_busy,
    output logic                             iss_valid,
    output logic                             iss_wr,
    output logic [rhs_pkg::TID_W-1:0]        iss_tid,
    output logic [rhs_pkg::ROW_W-1:0]        iss_row,
    output logic [rhs_pkg::COL_W-1:0]        iss_col,
    output logic                             iss_hit,
    output logic [(1<<rhs_pkg::TID_W)*CNT_W-1:0] thr_cnt
);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int THREADS = 1 << TID_W;

    req_t             ent [DEPTH];
    req_t             in_req;
    req_t             sel;
    logic [DEPTH-1:0] vld;
    logic             full, any, pick_hit, issue;
    logic [IDX_W-1:0] pick_idx;
    logic             open_vld;
    logic [ROW_W-1:0] open_row;

    assign req_ready = !full;
    assign in_req    = '{wr: req_wr, tid: req_tid, row: req_row, col: req_col, seq: '0};
    assign sel       = ent[pick_idx];

    rhs_buffer #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(req_valid), .push_req(in_req),
        .pop(issue), .pop_idx(pick_idx), .ent(ent), .vld(vld), .full(full)
    );

    rhs_picker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .ent(ent), .vld(vld), .open_vld(open_vld), .open_row(open_row),
        .any(any), .idx(pick_idx), .hit(pick_hit)
    );

    rhs_fsm #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(any), .bank_busy(bank_busy),
        .pick_hit(pick_hit), .issue(issue)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld  <= 1'b0;
            open_row  <= '0;
            iss_valid <= 1'b0;
            iss_wr    <= 1'b0;
            iss_tid   <= '0;
            iss_row   <= '0;
            iss_col   <= '0;
            iss_hit   <= 1'b0;
        end else begin
            iss_valid <= issue;
            if (issue) begin
                open_vld <= 1'b1;
                open_row <= sel.row;
                iss_wr   <= sel.wr;
                iss_tid  <= sel.tid;
                iss_row  <= sel.row;
                iss_col  <= sel.col;
                iss_hit  <= pick_hit;
            end
        end
    end

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                              cnt_q <= '0;
            else if (issue && sel.tid == TID_W'(t))  cnt_q <= cnt_q + 1'b1;
        end
        assign thr_cnt[t*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/rhs_checker.sv
module rhs_checker
    import rhs_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HIT_LAT  = 3,
    parameter int MISS_LAT = 9,
    parameter int CNT_W    = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              req_valid,
    input logic                              req_ready,
    input logic                              bank_busy,
    input logic                              iss_valid,
    input logic                              iss_hit,
    input logic [TID_W-1:0]                  iss_tid,
    input logic [ROW_W-1:0]                  iss_row,
    input logic [(1<<TID_W)*CNT_W-1:0]       thr_cnt
);
    localparam int OW = $clog2(DEPTH + 1) + 1;

    logic [OW-1:0]                     occ, live;
    logic [7:0]                        gap, lat_prev;
    logic                              seen;
    logic [ROW_W-1:0]                  prev_row;
    logic [(1<<TID_W)*CNT_W-1:0]       prev_thr;
    logic [CNT_W-1:0]                  cur_c, old_c;

    assign live  = occ - OW'(iss_valid);
    assign cur_c = thr_cnt[iss_tid*CNT_W +: CNT_W];
    assign old_c = prev_thr[iss_tid*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            gap      <= '0;
            lat_prev <= '0;
            seen     <= 1'b0;
            prev_row <= '0;
            prev_thr <= '0;
        end else begin
            occ      <= occ + OW'(req_valid && req_ready) - OW'(iss_valid);
            prev_thr <= thr_cnt;
            if (iss_valid) begin
                gap      <= 8'd1;
                lat_prev <= iss_hit ? 8'(HIT_LAT) : 8'(MISS_LAT);
                seen     <= 1'b1;
                prev_row <= iss_row;
            end else if (gap != 8'hFF) begin
                gap <= gap + 8'd1;
            end
        end
    end

    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (live < OW'(DEPTH))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        live <= OW'(DEPTH)); // R6
    AST_ISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid); // R3
    AST_ISS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && seen) |-> (gap >= lat_prev)); // R3
    AST_FIRST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !seen) |-> !iss_hit); // R5
    AST_HIT_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && seen && iss_hit) |-> (iss_row == prev_row)); // R4
    AST_MISS_NEW_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && seen && !iss_hit) |-> (iss_row != prev_row)); // R4
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !$past(bank_busy)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (cur_c == old_c + 1'b1)); // R9
endmodule

bind rowhit_sched rhs_checker #(
    .DEPTH(DEPTH), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bank_busy(bank_busy), .iss_valid(iss_valid), .iss_hit(iss_hit),
    .iss_tid(iss_tid), .iss_row(iss_row), .thr_cnt(thr_cnt)
);

// File: tb/rowhit_sched_bench.sv
`timescale 1ns/1ps
module rowhit_sched_bench;
    localparam int HIT_LAT  = 3;
    localparam int MISS_LAT = 9;
    localparam int CNT_W    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0, bank_busy = 1'b0;
    logic [1:0]  req_tid = '0;
    logic [7:0]  req_row = '0;
    logic [6:0]  req_col = '0;
    logic        req_ready, iss_valid, iss_wr, iss_hit;
    logic [1:0]  iss_tid;
    logic [7:0]  iss_row;
    logic [6:0]  iss_col;
    logic [63:0] thr_cnt;

    rowhit_sched #(.DEPTH(8), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .CNT_W(CNT_W)) u_rowhit_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_tid(req_tid), .req_row(req_row), .req_col(req_col),
        .bank_busy(bank_busy), .iss_valid(iss_valid), .iss_wr(iss_wr),
        .iss_tid(iss_tid), .iss_row(iss_row), .iss_col(iss_col),
        .iss_hit(iss_hit), .thr_cnt(thr_cnt)
    );

    always #4 clk = ~clk;

    int    n_chk = 0, n_fail = 0, n_iss = 0, cyc = 0, last_cyc = 0;
    bit    last_hit = 1'b0;
    string ph = "R10";
    logic [19:0] expq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // packed expectation: {chain, wr, hit, tid[1:0], row[7:0], col[6:0]}
    task automatic push_exp(input bit chain, input bit wr, input bit hit,
                            input int tid, input int row, input int col);
        expq.push_back({chain, wr, hit, 2'(tid), 8'(row), 7'(col)});
    endtask

    task automatic enq(input bit wr, input int tid, input int row, input int col);
        req_valid = 1'b1; req_wr = wr; req_tid = 2'(tid); req_row = 8'(row); req_col = 7'(col);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            n_iss++;
            if (expq.size() == 0) begin
                chk(1'b0, {ph, " R6 unexpected issue, row"}, iss_row, -1);
            end else begin
                logic [19:0] e;
                e = expq.pop_front();
                chk(iss_row == e[14:7], {ph, " R1 R2 R8 row"}, iss_row, e[14:7]);
                chk(iss_col == e[6:0],  {ph, " R2 R8 col"},    iss_col, e[6:0]);
                chk(iss_tid == e[16:15], {ph, " R8 tid"},      iss_tid, e[16:15]);
                chk(iss_wr == e[18],    {ph, " R8 wr"},        iss_wr,  e[18]);
                chk(iss_hit == e[17],   {ph, " R1 R4 R5 hit"}, iss_hit, e[17]);
                if (e[19])
                    chk(cyc - last_cyc == (last_hit ? HIT_LAT : MISS_LAT),
                        {ph, " R3 spacing"}, cyc - last_cyc, last_hit ? HIT_LAT : MISS_LAT);
            end
            last_cyc = cyc;
            last_hit = iss_hit;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R3 watchdog expired, pending=%0d expected=0", expq.size());
        report();
    end

    initial begin
        int open_t, base;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready at reset", req_ready, 1);
        chk(iss_valid == 1'b0, "R3 no issue at reset", iss_valid, 0);
        chk(thr_cnt == '0, "R9 counters at reset", int'(thr_cnt[31:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // starvation: thread 0 streams row 0, thread 1 waits on row 16
        ph = "R10";
        push_exp(1'b0, 1'b0, 1'b0, 0, 0, 0);
        for (int k = 1; k < 128; k++) push_exp(1'b1, k[0], 1'b1, 0, 0, k);
        push_exp(1'b1, 1'b1, 1'b0, 1, 16, 5);
        enq(1'b0, 0, 0, 0);
        enq(1'b1, 1, 16, 5);
        for (int k = 1; k < 128; k++) enq(k[0], 0, 0, k);
        drain();
        chk(thr_cnt[15:0] == 16'd128, "R10 R9 thread0 count", thr_cnt[15:0], 128);
        chk(thr_cnt[31:16] == 16'd1, "R10 R9 thread1 count", thr_cnt[31:16], 1);

        // fill to capacity under bank_busy, then a dropped request
        ph = "R6";
        bank_busy = 1'b1;
        base = n_iss;
        for (int j = 0; j < 8; j++) begin
            push_exp(j != 0, 1'b0, 1'b0, j % 3, 64 + j, 10 + j);
            enq(1'b0, j % 3, 64 + j, 10 + j);
        end
        chk(req_ready == 1'b0, "R6 ready low when full", req_ready, 0);
        req_valid = 1'b1; req_tid = 2'd3; req_row = 8'd0; req_col = 7'd99; req_wr = 1'b1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R6 still full", req_ready, 0);
        chk(n_iss == base, "R7 no issue while bank_busy", n_iss - base, 0);
        bank_busy = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        bank_busy = 1'b1;
        chk(n_iss == base + 8, "R6 dropped request never issued", n_iss - base, 8);
        chk(thr_cnt[63:48] == 16'd0, "R6 thread3 count", thr_cnt[63:48], 0);
        chk(req_ready == 1'b1, "R6 ready after drain", req_ready, 1);
        open_t = 71;

        // every hit/conflict mask over eight slots
        ph = "R11";
        for (int m = 0; m < 256; m++) begin
            bit first;
            int crow;
            crow  = m[0] ? 48 : 32;
            first = 1'b1;
            for (int j = 0; j < 8; j++)
                if (m[j]) begin
                    push_exp(!first, j[0] ^ m[1], 1'b1, j % 4, open_t, j);
                    first = 1'b0;
                end
            for (int j = 0; j < 8; j++)
                if (!m[j]) begin
                    push_exp(!first, j[0] ^ m[1], 1'b0, j % 4, crow + j, j);
                    first = 1'b0;
                end
            for (int j = 0; j < 8; j++)
                enq(j[0] ^ m[1], j % 4, m[j] ? open_t : crow + j, j);
            bank_busy = 1'b0;
            drain();
            bank_busy = 1'b1;
            for (int j = 0; j < 8; j++) if (!m[j]) open_t = crow + j;
        end

        chk(thr_cnt[15:0]  == 16'd643, "R9 thread0 total", thr_cnt[15:0],  643);
        chk(thr_cnt[31:16] == 16'd516, "R9 thread1 total", thr_cnt[31:16], 516);
        chk(thr_cnt[47:32] == 16'd514, "R9 thread2 total", thr_cnt[47:32], 514);
        chk(thr_cnt[63:48] == 16'd512, "R9 thread3 total", thr_cnt[63:48], 512);
        report();
    end
endmodule